// File: doc/BRIEF.md
# Prime-Modulo Bank Address Mapper

This block translates a linear word address into a bank number and an offset inside that bank, for a memory built from a prime number of banks (default 3), each holding a power-of-two number of words (default 8). The bank is the address reduced modulo the bank count. The offset is the address reduced modulo the words per bank, which is just the low address bits. The two moduli are coprime, so every address below banks × words lands on its own (bank, offset) pair. A power-of-two stride, which would hammer one bank under plain low-bit interleaving, is spread across all banks.

The bank number comes from a constant-modulo unit and no general divider is used. For a bank count of 3 it adds up the 2-bit digits of the address, since 4 ≡ 1 (mod 3), then folds that sum again in a second stage. Other bank counts fall back to a constant modulo operator. The result comes out through a fixed two-stage pipeline. Alongside it, an out-of-range flag marks addresses past the mapped span, and a conflict flag reports when a request maps to the same bank as the previous in-range request. Issuing requests to the banks is left to the surrounding logic.

Top module: `pmb_bank_mapper`

## Requirements
- R1: For a valid in-range request, map_bank_o equals the address modulo NUM_BANKS (default 3) and is always below NUM_BANKS.
- R2: map_offset_o equals the address modulo WORDS_PER_BANK (default 8), i.e. the low log2(WORDS_PER_BANK) address bits.
- R3: Every address from 0 to NUM_BANKS×WORDS_PER_BANK−1 yields a distinct (bank, offset) pair, covering all pairs exactly once.
- R4: map_oor_o is high exactly when the request address is at least NUM_BANKS×WORDS_PER_BANK (24 by default).
- R5: map_valid_o repeats req_valid_i two rising clock edges later, and the bank, offset and flags shown with it belong to that same request.
- R6: map_conflict_o is high with a valid in-range result whose bank equals that of the most recent earlier valid in-range request; idle cycles in between do not clear this history.
- R7: An out-of-range request never raises map_conflict_o and leaves the conflict history unchanged.
- R8: While rst_ni is low, map_valid_o and map_conflict_o are low, and the first in-range request after reset raises no conflict.
- R9: The stride sequence 0, 8, 16 maps to banks 0, 2, 1 with no conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | ADDR_W | Linear word address |
| map_valid_o | output | 1 | Result strobe, two edges after the request |
| map_bank_o | output | BANK_W | Bank number |
| map_offset_o | output | OFF_W | Offset within the bank |
| map_oor_o | output | 1 | Address beyond the mapped span |
| map_conflict_o | output | 1 | Same bank as previous in-range request |

## Verification
Every result (bank, offset, out-of-range flag, conflict flag and valid strobe) is due two rising edges after its request is sampled. The bench drives on falling edges and keeps a two-deep queue of the requests it has issued. At each falling edge it compares the outputs against the request that left the queue, so the expected value and the observed value always refer to the same request. The conflict reference tracks its own last in-range bank, updated in request order. The exhaustive sweep also collects the (bank, offset) pairs to check that they are unique.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  // Repeated 2-bit digit summation, valid because 4 mod 3 == 1.
  function automatic logic [1:0] mod3_fold(input logic [31:0] v_in);
    logic [31:0] v;
    logic [31:0] s;
    v = v_in;
    for (int it = 0; it < 6; it++) begin
      s = '0;
      for (int d = 0; d < 16; d++) s = s + 32'(v[2*d +: 2]);
      v = s;
    end
    return (v[1:0] == 2'd3) ? 2'd0 : v[1:0];
  endfunction
endpackage

// File: rtl/pmb_bank_reduce.sv
module pmb_bank_reduce #(
  parameter int ADDR_W    = 6,
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o
);
  import pmb_pkg::*;

  generate
    if (NUM_BANKS == 3) begin : g_digit
      localparam int NDIG  = (ADDR_W + 1) / 2;
      localparam int SUM_W = $clog2(3 * NDIG + 1);
      logic [ADDR_W+1:0] addr_pad;
      logic [SUM_W-1:0]  sum_d, sum_q;
      logic [BANK_W-1:0] bank_q;

      assign addr_pad = {2'b00, addr_i};

      always_comb begin
        sum_d = '0;
        for (int d = 0; d < NDIG; d++) sum_d = sum_d + SUM_W'(addr_pad[2*d +: 2]);
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sum_q  <= '0;
          bank_q <= '0;
        end else begin
          sum_q  <= sum_d;
          bank_q <= BANK_W'(mod3_fold(32'(sum_q)));
        end
      end
      assign bank_o = bank_q;
    end else begin : g_const
      logic [BANK_W-1:0] rem_q, bank_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rem_q  <= '0;
          bank_q <= '0;
        end else begin
          rem_q  <= BANK_W'(32'(addr_i) % NUM_BANKS);
          bank_q <= rem_q;
        end
      end
      assign bank_o = bank_q;
    end
  endgenerate
endmodule

// File: rtl/pmb_conflict_track.sv
module pmb_conflict_track #(
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              conflict_o
);
  logic              have_q;
  logic [BANK_W-1:0] last_q;

  // hit_i is held for one cycle per result; history captures it at the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else if (hit_i) begin
      have_q <= 1'b1;
      last_q <= bank_i;
    end
  end

  assign conflict_o = hit_i && have_q && (last_q == bank_i);
endmodule

// File: rtl/pmb_bank_mapper.sv
module pmb_bank_mapper #(
  parameter int NUM_BANKS      = 3,
  parameter int WORDS_PER_BANK = 8,
  parameter int ADDR_W         = 6,
  localparam int SPAN          = NUM_BANKS * WORDS_PER_BANK,
  localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OFF_W         = (WORDS_PER_BANK > 1) ? $clog2(WORDS_PER_BANK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              map_valid_o,
  output logic [BANK_W-1:0] map_bank_o,
  output logic [OFF_W-1:0]  map_offset_o,
  output logic              map_oor_o,
  output logic              map_conflict_o
);
  logic [1:0]       vld_q;
  logic [1:0]       oor_q;
  logic [OFF_W-1:0] off_q [2];
  logic             oor_d;

  assign oor_d = 32'(req_addr_i) >= SPAN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      oor_q  <= '0;
      off_q[0] <= '0;
      off_q[1] <= '0;
    end else begin
      vld_q  <= {vld_q[0], req_valid_i};
      oor_q  <= {oor_q[0], oor_d};
      off_q[0] <= req_addr_i[OFF_W-1:0];
      off_q[1] <= off_q[0];
    end
  end

  pmb_bank_reduce #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_reduce (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(req_addr_i),
    .bank_o(map_bank_o)
  );

  pmb_conflict_track #(
    .BANK_W(BANK_W)
  ) u_conflict (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (vld_q[1] && !oor_q[1]),
    .bank_i    (map_bank_o),
    .conflict_o(map_conflict_o)
  );

  assign map_valid_o  = vld_q[1];
  assign map_oor_o    = oor_q[1];
  assign map_offset_o = off_q[1];
endmodule

// File: rtl/pmb_mapper_chk.sv
module pmb_mapper_chk #(
  parameter int NUM_BANKS      = 3,
  parameter int WORDS_PER_BANK = 8,
  parameter int ADDR_W         = 6,
  parameter int BANK_W         = 2,
  parameter int OFF_W          = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              map_valid_o,
  input logic [BANK_W-1:0] map_bank_o,
  input logic [OFF_W-1:0]  map_offset_o,
  input logic              map_oor_o,
  input logic              map_conflict_o
);
  localparam int SPAN = NUM_BANKS * WORDS_PER_BANK;
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R5
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (map_valid_o == $past(req_valid_i, 2)));

  // R1
  bank_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && map_valid_o && !map_oor_o) |->
      (32'(map_bank_o) == 32'($past(req_addr_i, 2)) % NUM_BANKS));

  // R2
  offset_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && map_valid_o) |->
      (32'(map_offset_o) == 32'($past(req_addr_i, 2)) % WORDS_PER_BANK));

  // R4
  oor_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && map_valid_o) |->
      (map_oor_o == (32'($past(req_addr_i, 2)) >= SPAN)));

  // R7
  conflict_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_conflict_o |-> (map_valid_o && !map_oor_o));
endmodule

bind pmb_bank_mapper pmb_mapper_chk #(
  .NUM_BANKS     (NUM_BANKS),
  .WORDS_PER_BANK(WORDS_PER_BANK),
  .ADDR_W        (ADDR_W),
  .BANK_W        (BANK_W),
  .OFF_W         (OFF_W)
) u_chk (.*);

// File: tb/pmb_bank_mapper_tb.sv
module pmb_bank_mapper_tb;
  localparam int NB   = 3;
  localparam int NW   = 8;
  localparam int AW   = 6;
  localparam int SPAN = NB * NW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_v = 1'b0;
  logic [AW-1:0] req_a = '0;
  logic       m_v, m_oor, m_cf;
  logic [1:0] m_bank;
  logic [2:0] m_off;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit record = 0;
  int seen [NB][NW];

  // two-deep queue of issued requests
  bit p_v [2];
  int p_a [2];
  bit ref_have = 0;
  int ref_last = 0;

  always #4 clk = ~clk;

  pmb_bank_mapper #(.NUM_BANKS(NB), .WORDS_PER_BANK(NW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_addr_i(req_a),
    .map_valid_o(m_v), .map_bank_o(m_bank), .map_offset_o(m_off),
    .map_oor_o(m_oor), .map_conflict_o(m_cf));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    bit ev, eoor, ecf;
    int a;
    ev = p_v[1];
    a  = p_a[1];
    chk(m_v == ev, "R5 valid", int'(m_v), int'(ev));
    if (ev) begin
      eoor = (a >= SPAN);
      chk(m_oor == eoor, "R4 oor", int'(m_oor), int'(eoor));
      chk(int'(m_off) == a % NW, "R2 offset", int'(m_off), a % NW);
      if (!eoor) begin
        chk(int'(m_bank) == a % NB, "R1 bank", int'(m_bank), a % NB);
        ecf = ref_have && (ref_last == a % NB);
        ref_have = 1;
        ref_last = a % NB;
        if (record && int'(m_bank) < NB) seen[m_bank][m_off]++;
      end else begin
        ecf = 0;
      end
      chk(m_cf == ecf, "R6/R7 conflict", int'(m_cf), int'(ecf));
    end else begin
      chk(m_cf == 1'b0, "R6 conflict idle", int'(m_cf), 0);
    end
  endtask

  task automatic step(input bit v, input int a);
    @(negedge clk);
    compare();
    p_v[1] = p_v[0]; p_a[1] = p_a[0];
    p_v[0] = v;      p_a[0] = a;
    req_v = v;
    req_a = AW'(a);
  endtask

  task automatic flush();
    step(0, 0); step(0, 0); step(0, 0);
  endtask

  initial begin
    p_v[0] = 0; p_v[1] = 0; p_a[0] = 0; p_a[1] = 0;
    foreach (seen[b, o]) seen[b][o] = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(m_v == 1'b0, "R8 reset valid", int'(m_v), 0);
    chk(m_cf == 1'b0, "R8 reset conflict", int'(m_cf), 0);
    rst_n = 1'b1;

    // R8: first request after reset, same bank as nothing
    step(1, 3);
    step(1, 5);
    flush();

    // R1 R2 R3 R4: exhaustive sweep, back to back
    record = 1;
    for (int a = 0; a < (1 << AW); a++) step(1, a);
    flush();
    record = 0;
    foreach (seen[b, o]) chk(seen[b][o] == 1, "R3 unique pair", seen[b][o], 1);

    // R6: stride of NB hits one bank; idle gaps keep history
    step(1, 0); step(1, 3); step(0, 0); step(0, 0); step(1, 6);
    // R7: out-of-range in between neither flags nor resets history
    step(1, 40); step(1, 9); step(1, 63); step(1, 30); step(1, 1);
    flush();

    // R9: power-of-two stride rotates through every bank
    step(1, 0); step(1, 8); step(1, 16); step(1, 0);
    flush();

    // mixed pattern with gaps
    begin
      logic [7:0] lfsr = 8'hA5;
      for (int i = 0; i < 300; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        step(lfsr[7] | lfsr[2], int'(lfsr[5:0]));
      end
    end
    flush();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule